// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block lets an external two-wire bus master read and write a bank of 8-bit control registers. The bus clock and data lines are sampled by the system clock, passed through synchronisers, and turned into edge, start and stop events. These events drive a byte-level state machine. After a start, the slave receives a device address byte. A write then loads a register pointer, and every following data byte goes to that pointer. A read streams bytes out from the pointer. The slave pulls the data line low only through an open-drain enable output. The pointer stops at the top register and does not wrap.

The usual sequence is a write that sets the base address, then a repeated start, then a read from that base. A second read-only port lets on-chip logic look at any register combinationally.

State machine: `ST_IDLE` waits for a start. `ST_DEV_ADDR` shifts in the device address byte and moves to `ST_DEV_ACK` on a match or to `ST_IGNORE` on a mismatch. `ST_DEV_ACK` goes to `ST_PTR_RX` for a write or to `ST_RD_TX` for a read. `ST_PTR_RX` moves to `ST_PTR_ACK` for an in-range base or to `ST_IGNORE` otherwise. `ST_PTR_ACK` and `ST_WR_ACK` go to `ST_WR_RX`, and `ST_WR_RX` goes to `ST_WR_ACK` after each byte. `ST_RD_TX` goes to `ST_RD_ACK` after eight bits. `ST_RD_ACK` returns to `ST_RD_TX` on a master acknowledge or goes to `ST_IGNORE` on a master not-acknowledge. From any state, a start leads to `ST_DEV_ADDR` and a stop leads to `ST_IDLE`.

Top module: `i2c_reg_port`

## Requirements
- R1: The slave does nothing until it sees a start, which is SDA falling while SCL is high. Bits clocked without a start are not acknowledged.
- R2: The slave changes its SDA drive only after a detected SCL falling edge. It holds that drive through the following SCL high phase.
- R3: The first byte after a start is received MSB first. It holds a 7-bit device address in bits 7..1 and a direction bit in bit 0, where 1 means read. When the address equals 7'b1001100, the slave pulls SDA low for the ninth SCL pulse.
- R4: On an address mismatch the slave leaves SDA released and ignores all later bytes until the next start. No register changes.
- R5: In a write, the second byte is the register base address. It is acknowledged when it is at most NUM_REGS-1 (8'h3F by default).
- R6: Each later write data byte is acknowledged and stored at the pointer. The pointer then advances by one.
- R7: When the pointer is at NUM_REGS-1 it does not advance, so further bytes overwrite the last register.
- R8: A base address above NUM_REGS-1 is not acknowledged. The pointer and all registers keep their values.
- R9: A read sends bytes MSB first, starting at the current pointer. The pointer advances (saturating) after each byte, and a master acknowledge continues the stream.
- R10: A master not-acknowledge ends the read. The slave keeps SDA released until the next start.
- R11: A repeated start, meaning a start with no stop before it, is accepted mid-transaction and begins a new address byte.
- R12: A stop, meaning SDA rising while SCL is high, returns the slave to idle at any bit position. A partly received byte is discarded.
- R13: The host port returns the register at host_addr combinationally, or 8'h00 for an address of NUM_REGS or more. All registers reset to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| host_addr | input | 8 | Register index for the on-chip read port |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The assertions assume a well-behaved master. It keeps SCL low for at least three system clocks around every data change, and it never issues a start or stop while the slave is driving the line. Under those conditions every change of sda_oe follows two cycles of SCL low at the pin. The bench's master model sets SDA one quarter-period after each SCL falling edge and samples it mid-high. It inserts starts and stops only while the slave has released the bus, including the stop in the middle of a byte. Random transactions draw base addresses and lengths near the top register so that saturation is reached often.

// File: rtl/i2c_port_pkg.sv
`timescale 1ns/1ps
package i2c_port_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_PTR_RX,
        ST_PTR_ACK,
        ST_WR_RX,
        ST_WR_ACK,
        ST_RD_TX,
        ST_RD_ACK,
        ST_IGNORE
    } port_state_t;

    function automatic logic [7:0] sat_inc(input logic [7:0] v, input logic [7:0] top);
        return (v >= top) ? top : v + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ch;
    logic [STAGES-1:0] sda_ch;
    logic              scl_s;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ch <= '1;
                    sda_ch <= '1;
                end else begin
                    scl_ch <= scl_in;
                    sda_ch <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ch <= '1;
                    sda_ch <= '1;
                end else begin
                    scl_ch <= {scl_ch[STAGES-2:0], scl_in};
                    sda_ch <= {sda_ch[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ch[STAGES-1];
    assign sda_s = sda_ch[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
module i2c_reg_bank #(
    parameter int NUM_REGS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr_a,
    output logic [7:0] rd_data_a,
    input  logic [7:0] rd_addr_b,
    output logic [7:0] rd_data_b
);
    localparam int         IDXW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    logic [7:0] mem [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= 8'h00;
                end else if (wr_en && (wr_addr == 8'(g))) begin
                    mem[g] <= wr_data;
                end
            end
        end
    endgenerate

    function automatic logic [7:0] fetch(input logic [7:0] a);
        logic [IDXW-1:0] idx;
        idx = a[IDXW-1:0];
        return ({1'b0, a} < LIMIT) ? mem[idx] : 8'h00;
    endfunction

    assign rd_data_a = fetch(rd_addr_a);
    assign rd_data_b = fetch(rd_addr_b);

endmodule

// File: rtl/i2c_port_fsm.sv
`timescale 1ns/1ps
module i2c_port_fsm
    import i2c_port_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001100,
    parameter int         NUM_REGS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic [7:0]  rd_data,
    output port_state_t state,
    output logic [7:0]  ptr,
    output logic        wr_en,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        sda_low
);
    localparam logic [7:0] MAX_PTR = 8'(NUM_REGS - 1);

    port_state_t state_n;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic        ack_ok;
    logic        rw_q;
    logic        mst_ack_q;
    logic        byte_done;
    logic [7:0]  byte_in;
    logic        drive_n;

    assign byte_done = (bit_cnt == 4'd8);
    assign byte_in   = {shreg[6:0], sda_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_DEV_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_DEV_ADDR: if (scl_fall && byte_done) state_n = ack_ok ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:  if (scl_fall) state_n = rw_q ? ST_RD_TX : ST_PTR_RX;
                ST_PTR_RX:   if (scl_fall && byte_done) state_n = ack_ok ? ST_PTR_ACK : ST_IGNORE;
                ST_PTR_ACK:  if (scl_fall) state_n = ST_WR_RX;
                ST_WR_RX:    if (scl_fall && byte_done) state_n = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_n = ST_WR_RX;
                ST_RD_TX:    if (scl_fall && byte_done) state_n = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_n = mst_ack_q ? ST_RD_TX : ST_IGNORE;
                ST_IGNORE:   state_n = ST_IGNORE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= 4'd0;
            shreg     <= 8'h00;
            ack_ok    <= 1'b0;
            rw_q      <= 1'b0;
            mst_ack_q <= 1'b0;
            ptr       <= 8'h00;
            wr_en     <= 1'b0;
            wr_addr   <= 8'h00;
            wr_data   <= 8'h00;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= 4'd0;
            end else begin
                unique case (state)
                    ST_DEV_ADDR, ST_PTR_RX, ST_WR_RX: begin
                        if (scl_rise && !byte_done) begin
                            shreg   <= byte_in;
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                if (state == ST_DEV_ADDR) begin
                                    ack_ok <= (byte_in[7:1] == DEV_ADDR);
                                    rw_q   <= byte_in[0];
                                end else if (state == ST_PTR_RX) begin
                                    ack_ok <= (byte_in <= MAX_PTR);
                                    if (byte_in <= MAX_PTR) ptr <= byte_in;
                                end else begin
                                    ack_ok  <= 1'b1;
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= byte_in;
                                    ptr     <= sat_inc(ptr, MAX_PTR);
                                end
                            end
                        end else if (scl_fall && byte_done) begin
                            bit_cnt <= 4'd0;
                        end
                    end
                    ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= 4'd0;
                            if (state == ST_DEV_ACK && rw_q) shreg <= rd_data;
                        end
                    end
                    ST_RD_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (byte_done) bit_cnt <= 4'd0;
                            else           shreg   <= {shreg[6:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack_q <= ~sda_s;
                            ptr       <= sat_inc(ptr, MAX_PTR);
                        end else if (scl_fall && mst_ack_q) begin
                            shreg   <= rd_data;
                            bit_cnt <= 4'd0;
                        end
                    end
                    ST_IDLE, ST_IGNORE: bit_cnt <= 4'd0;
                    default:            bit_cnt <= 4'd0;
                endcase
            end
        end
    end

    // open-drain drive decision, applied only at SCL falling edges
    always_comb begin
        unique case (state_n)
            ST_DEV_ACK, ST_PTR_ACK, ST_WR_ACK: drive_n = 1'b1;
            ST_RD_TX: drive_n = (state == ST_RD_TX) ? ~shreg[6] : ~rd_data[7];
            default:  drive_n = 1'b0;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      sda_low <= 1'b0;
        else if (start_det || stop_det)  sda_low <= 1'b0;
        else if (scl_fall)               sda_low <= drive_n;
    end

endmodule

// File: rtl/i2c_reg_port.sv
`timescale 1ns/1ps
module i2c_reg_port
    import i2c_port_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1001100,
    parameter int         NUM_REGS    = 64,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [7:0] host_addr,
    output logic [7:0] host_rdata
);
    logic        sda_s;
    logic        scl_rise;
    logic        scl_fall;
    logic        start_det;
    logic        stop_det;
    port_state_t state;
    logic [7:0]  ptr;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [7:0]  fsm_rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_port_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (fsm_rdata),
        .state     (state),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_low   (sda_oe)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (ptr),
        .rd_data_a (fsm_rdata),
        .rd_addr_b (host_addr),
        .rd_data_b (host_rdata)
    );

endmodule

// File: rtl/i2c_reg_port_chk.sv
`timescale 1ns/1ps
module i2c_reg_port_chk
    import i2c_port_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_in,
    input logic        sda_oe,
    input logic        start_det,
    input logic        stop_det,
    input port_state_t state,
    input logic [7:0]  ptr,
    input logic        wr_en,
    input logic [7:0]  wr_addr
);
    localparam logic [7:0] MAX_PTR = 8'(NUM_REGS - 1);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_in, 1) && !$past(scl_in, 2))); // R2

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe); // R4

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == ((wr_addr == MAX_PTR) ? MAX_PTR : wr_addr + 8'd1))); // R6

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= MAX_PTR); // R7

    AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= MAX_PTR)); // R7

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV_ADDR)); // R11

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE)); // R12

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R12

endmodule

bind i2c_reg_port i2c_reg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (state),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr)
);

// File: tb/tb_i2c_reg_port.sv
`timescale 1ns/1ps
module tb_i2c_reg_port;
    localparam int Q    = 8;
    localparam int NREG = 64;
    localparam logic [7:0] ADDR_W = 8'h98;
    localparam logic [7:0] ADDR_R = 8'h99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] mem_m [NREG];
    logic [7:0] ptr_m;
    logic [7:0] dbuf [8];

    always #2.5 clk = ~clk;

    i2c_reg_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(Q);
        scl_m = 1'b1; wt(2 * Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        b = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p >= 8'(NREG - 1)) ? 8'(NREG - 1) : p + 8'd1;
    endfunction

    task automatic host_peek(input logic [7:0] a, output logic [7:0] v);
        host_addr = a; wt(1);
        v = host_rdata;
    endtask

    // write transaction: base then n bytes from dbuf; checks acks and updates the model
    task automatic do_write(input logic [7:0] base, input int n, input string req);
        logic ack;
        logic [7:0] p;
        bus_start();
        put_byte(ADDR_W, ack); chk("R3 addr ack", ack, 1);
        put_byte(base, ack);   chk("R5 base ack", ack, 1);
        p = base;
        for (int i = 0; i < n; i++) begin
            put_byte(dbuf[i], ack); chk(req, ack, 1);
            mem_m[p] = dbuf[i];
            p = nxt(p);
        end
        ptr_m = p;
        bus_stop();
    endtask

    // set base, repeated start, read n bytes and compare against the model
    task automatic do_read(input logic [7:0] base, input int n, input string req);
        logic ack;
        logic [7:0] v;
        logic [7:0] p;
        bus_start();
        put_byte(ADDR_W, ack); chk("R3 addr ack", ack, 1);
        put_byte(base, ack);   chk("R5 base ack", ack, 1);
        bus_rstart();
        put_byte(ADDR_R, ack); chk("R11 rstart addr ack", ack, 1);
        p = base;
        for (int i = 0; i < n; i++) begin
            get_byte(v, (i != n - 1));
            chk(req, v, mem_m[p]);
            p = nxt(p);
        end
        ptr_m = p;
        chk("R10 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 190000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        for (int i = 0; i < NREG; i++) mem_m[i] = 8'h00;
        ptr_m = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(5);

        // reset state (R13)
        chk("R13 reset oe", sda_oe, 0);
        host_peek(8'h05, v); chk("R13 reset reg", v, 8'h00);
        host_peek(8'h50, v); chk("R13 out of range host read", v, 8'h00);

        // R1: bits with no start are not acknowledged
        scl_m = 1'b0; wt(Q);
        put_byte(ADDR_W, ack); chk("R1 no start no ack", ack, 0);
        bus_stop();

        // R3/R5/R6 directed write, checked through host port
        dbuf[0] = 8'hA5; dbuf[1] = 8'h3C; dbuf[2] = 8'h0F;
        do_write(8'h10, 3, "R6 data ack");
        host_peek(8'h10, v); chk("R6 reg10", v, 8'hA5);
        host_peek(8'h11, v); chk("R6 reg11", v, 8'h3C);
        host_peek(8'h12, v); chk("R6 reg12", v, 8'h0F);

        // R9/R10/R11 read back through repeated start
        do_read(8'h10, 3, "R9 read data");

        // R7 saturation at top register
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
        do_write(8'h3E, 3, "R7 data ack at top");
        host_peek(8'h3E, v); chk("R7 reg3E", v, 8'h11);
        host_peek(8'h3F, v); chk("R7 reg3F overwritten", v, 8'h33);

        // R8 out-of-range base: no ack, pointer kept at 3F
        bus_start();
        put_byte(ADDR_W, ack); chk("R3 addr ack", ack, 1);
        put_byte(8'h40, ack);  chk("R8 base nack", ack, 0);
        put_byte(8'h77, ack);  chk("R8 data ignored", ack, 0);
        bus_stop();
        bus_start();
        put_byte(ADDR_R, ack); chk("R3 read addr ack", ack, 1);
        get_byte(v, 1'b0);     chk("R8 pointer unchanged", v, 8'h33);
        bus_stop();
        host_peek(8'h3F, v);   chk("R8 reg unchanged", v, 8'h33);

        // R4 address mismatch
        bus_start();
        put_byte(8'h9A, ack);  chk("R4 mismatch nack", ack, 0);
        put_byte(8'h10, ack);  chk("R4 later byte nack", ack, 0);
        put_byte(8'hFF, ack);  chk("R4 data nack", ack, 0);
        bus_stop();
        host_peek(8'h10, v);   chk("R4 reg untouched", v, 8'hA5);

        // R12 stop in the middle of a data byte
        bus_start();
        put_byte(ADDR_W, ack); chk("R3 addr ack", ack, 1);
        put_byte(8'h20, ack);  chk("R5 base ack", ack, 1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        chk("R12 released after stop", sda_oe, 0);
        host_peek(8'h20, v);   chk("R12 partial byte dropped", v, 8'h00);
        dbuf[0] = 8'h5A;
        do_write(8'h20, 1, "R12 new transfer after stop");
        host_peek(8'h20, v);   chk("R12 write after stop", v, 8'h5A);

        // random transactions
        for (int it = 0; it < 12; it++) begin
            logic [7:0] b;
            int n;
            b = 8'($urandom_range(0, NREG - 1));
            if (it % 3 == 0) b = 8'($urandom_range(NREG - 3, NREG - 1));
            n = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
            do_write(b, n, "R6 random data ack");
            b = 8'($urandom_range(0, NREG - 1));
            if (it % 2 == 0) b = 8'($urandom_range(NREG - 3, NREG - 1));
            do_read(b, $urandom_range(1, 4), "R9 random read");
        end

        // final sweep through the host port
        for (int a = 0; a < NREG; a++) begin
            host_peek(8'(a), v);
            chk("R13 host sweep", v, mem_m[a]);
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule